// File: doc/BRIEF.md
# Registered Byte Comparator Slice with Priority Cascade

This block keeps one byte in a register and compares it, every cycle, with the byte on a shared data bus. A two-bit select picks one of four register operations. The register can keep its value, drive itself onto the bus, take the bus value in parallel, or take in one serial bit per clock. The comparator reports whether the stored byte is above, equal to or below the bus value. A mode input picks an unsigned or a two's complement compare.

The three status results copy open-collector pins. Each has a pull-down enable and a resolved level, which is the level the pin would have with a pull-up. A status-enable input can turn all three off. A shared pin carries the serial input or an incoming priority, and a second shared pin carries the serial output or an outgoing priority. Slices can therefore be chained from the most significant byte down. A slice passes priority on only while every slice above it has seen equality.

Top module: `regcmp_slice`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the stored byte to zero.
- R2: With select 00 (hold) the stored byte does not change at the rising edge, whatever the bus value.
- R3: With select 01 (read) the stored byte is unchanged and appears on bus_out with bus_oe high. In every other select value bus_oe is low and bus_out is zero.
- R4: With select 11 (load) the bus value is captured at the rising edge.
- R5: With select 10 (shift) the byte moves one place toward the most significant bit at the rising edge, with pri_si entering bit 0. While shift is selected, pri_so shows the stored bit 7.
- R6: With stat_en_n low, pri_si high and cmp_signed low, the three levels {gt_lvl, eq_lvl, lt_lvl} form an unsigned compare of register against bus. The matching level is 1 and the other two are 0.
- R7: With cmp_signed high, the same compare treats both bytes as two's complement numbers.
- R8: With stat_en_n high, all three pull-down enables are 0 and all three levels are 1.
- R9: With stat_en_n low and pri_si low, gt_lvl and lt_lvl are 1 (off), and eq_lvl is 1 exactly when register equals bus.
- R10: In every select other than shift, pri_so equals pri_si AND (register equals bus).
- R11: Each status level is the inverse of its pull-down enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 2 | Register operation: 00 hold, 01 read, 10 shift, 11 load |
| cmp_signed | input | 1 | 1 selects a two's complement compare, 0 selects unsigned |
| stat_en_n | input | 1 | Status enable, active low |
| pri_si | input | 1 | Serial data input or incoming priority |
| bus_in | input | 8 | Value on the shared data bus |
| bus_out | output | 8 | Register value driven in read mode, zero otherwise |
| bus_oe | output | 1 | Bus driver enable |
| pri_so | output | 1 | Serial data output or outgoing priority |
| gt_pd | output | 1 | Pull-down enable of the greater-than pin |
| eq_pd | output | 1 | Pull-down enable of the equal pin |
| lt_pd | output | 1 | Pull-down enable of the less-than pin |
| gt_lvl | output | 1 | Resolved greater-than level |
| eq_lvl | output | 1 | Resolved equal level |
| lt_lvl | output | 1 | Resolved less-than level |

## Verification
A change to the stored byte happens at the rising edge that samples the select and data. It becomes visible half a clock later, when the bench reads it back through a read cycle. The status levels, the pull-down enables, bus_oe and pri_so depend only on the present inputs and the present register. The bench therefore checks them in the same cycle, one time unit after it drives the inputs on the falling edge, against its model register. The model register moves forward only at the rising edge that follows.

// File: rtl/regcmp_pkg.sv
package regcmp_pkg;
   typedef enum logic [1:0] {
      SEL_HOLD  = 2'b00,
      SEL_READ  = 2'b01,
      SEL_SHIFT = 2'b10,
      SEL_LOAD  = 2'b11
   } regcmp_sel_e;

   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } regcmp_rel_t;
endpackage

// File: rtl/regcmp_shreg.sv
module regcmp_shreg
   import regcmp_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  regcmp_sel_e  sel,
   input  logic         ser_in,
   input  logic [W-1:0] par_in,
   output logic [W-1:0] q
);
   initial begin
      if (W < 2) $error("regcmp_shreg: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         case (sel)
            SEL_SHIFT: q <= {q[W-2:0], ser_in};
            SEL_LOAD:  q <= par_in;
            default:   q <= q;
         endcase
      end
   end

   // R2 / R3: hold and read leave the register untouched
   p_keep_r2: assert property (@(posedge clk) disable iff (rst)
      (sel == SEL_HOLD || sel == SEL_READ) |=> $stable(q));
   // R4: load captures the bus
   p_load_r4: assert property (@(posedge clk) disable iff (rst)
      (sel == SEL_LOAD) |=> (q == $past(par_in)));
   // R5: shift moves toward the MSB with the serial bit at bit 0
   p_shift_r5: assert property (@(posedge clk) disable iff (rst)
      (sel == SEL_SHIFT) |=> (q == {$past(q[W-2:0]), $past(ser_in)}));
endmodule

// File: rtl/regcmp_compare.sv
module regcmp_compare
   import regcmp_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         signed_mode,
   output regcmp_rel_t  rel
);
   localparam int MSB = W - 1;

   logic [W-1:0] ax, bx;
   logic         gt_r, lt_r;

   // Inverting the sign bits maps two's complement order onto unsigned order.
   assign ax = {a[MSB] ^ signed_mode, a[MSB-1:0]};
   assign bx = {b[MSB] ^ signed_mode, b[MSB-1:0]};

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] gtc, ltc;
         assign gtc[W] = 1'b0;
         assign ltc[W] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign gtc[i] = gtc[i+1] | (~ltc[i+1] & ax[i] & ~bx[i]);
            assign ltc[i] = ltc[i+1] | (~gtc[i+1] & ~ax[i] & bx[i]);
         end
         assign gt_r = gtc[0];
         assign lt_r = ltc[0];
      end else begin : g_direct
         assign gt_r = (ax > bx);
         assign lt_r = (ax < bx);
      end
   endgenerate

   assign rel.gt = gt_r;
   assign rel.lt = lt_r;
   assign rel.eq = ~gt_r & ~lt_r;

   // R6: exactly one relation holds
   always_comb begin
      p_rel_onehot_r6: assert ($countones({gt_r, lt_r}) <= 1);
   end
endmodule

// File: rtl/regcmp_status.sv
module regcmp_status
   import regcmp_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  regcmp_rel_t rel,
   input  logic        stat_en_n,
   input  logic        pri_in,
   input  logic        shift_mode,
   input  logic        q_msb,
   output logic        pd_gt,
   output logic        pd_eq,
   output logic        pd_lt,
   output logic        pri_out
);
   logic en;

   assign en      = ~stat_en_n;
   assign pd_eq   = en & ~rel.eq;
   assign pd_gt   = en & pri_in & ~rel.gt;
   assign pd_lt   = en & pri_in & ~rel.lt;
   assign pri_out = shift_mode ? q_msb : (pri_in & rel.eq);

   // R8: disabled status pulls nothing low
   p_off_r8: assert property (@(posedge clk) disable iff (rst)
      stat_en_n |-> !(pd_gt | pd_eq | pd_lt));
   // R9: without priority only the equal pin may pull low
   p_pri_gate_r9: assert property (@(posedge clk) disable iff (rst)
      !pri_in |-> !(pd_gt | pd_lt));
   // R10: outgoing priority never appears without incoming priority
   p_chain_r10: assert property (@(posedge clk) disable iff (rst)
      (!shift_mode && !pri_in) |-> !pri_out);
endmodule

// File: rtl/regcmp_slice.sv
module regcmp_slice
   import regcmp_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [1:0]   sel,
   input  logic         cmp_signed,
   input  logic         stat_en_n,
   input  logic         pri_si,
   input  logic [W-1:0] bus_in,
   output logic [W-1:0] bus_out,
   output logic         bus_oe,
   output logic         pri_so,
   output logic         gt_pd,
   output logic         eq_pd,
   output logic         lt_pd,
   output logic         gt_lvl,
   output logic         eq_lvl,
   output logic         lt_lvl
);
   localparam int MSB = W - 1;

   initial begin
      if (W < 2) $error("regcmp_slice: W must be at least 2");
   end

   regcmp_sel_e  sel_e;
   logic [W-1:0] q;
   regcmp_rel_t  rel;

   assign sel_e = regcmp_sel_e'(sel);

   regcmp_shreg #(.W(W)) i_shreg (
      .clk(clk), .rst(rst), .sel(sel_e), .ser_in(pri_si),
      .par_in(bus_in), .q(q)
   );

   regcmp_compare #(.W(W), .RIPPLE(RIPPLE)) i_cmp (
      .a(q), .b(bus_in), .signed_mode(cmp_signed), .rel(rel)
   );

   regcmp_status i_status (
      .clk(clk), .rst(rst), .rel(rel), .stat_en_n(stat_en_n),
      .pri_in(pri_si), .shift_mode(sel_e == SEL_SHIFT), .q_msb(q[MSB]),
      .pd_gt(gt_pd), .pd_eq(eq_pd), .pd_lt(lt_pd), .pri_out(pri_so)
   );

   assign bus_oe  = (sel_e == SEL_READ);
   assign bus_out = bus_oe ? q : '0;

   assign gt_lvl = ~gt_pd;
   assign eq_lvl = ~eq_pd;
   assign lt_lvl = ~lt_pd;

   // R3: no bus drive outside read
   p_bus_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      !bus_oe |-> (bus_out == '0));
   // R6 / R11: enabled and prioritised status shows exactly one high level
   p_one_level_r11: assert property (@(posedge clk) disable iff (rst)
      (!stat_en_n && pri_si) |-> ($countones({gt_lvl, eq_lvl, lt_lvl}) == 1));
endmodule

// File: tb/test_regcmp_slice.sv
`timescale 1ns/100ps
module test_regcmp_slice;
   logic       clk = 1'b0;
   logic       rst;
   logic [1:0] sel;
   logic       cmp_signed, stat_en_n, pri_si;
   logic [7:0] bus_in, bus_out;
   logic       bus_oe, pri_so, gt_pd, eq_pd, lt_pd, gt_lvl, eq_lvl, lt_lvl;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [7:0] mq;

   always #2.5 clk = ~clk;

   regcmp_slice i_regcmp_slice (
      .clk(clk), .rst(rst), .sel(sel), .cmp_signed(cmp_signed),
      .stat_en_n(stat_en_n), .pri_si(pri_si), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .pri_so(pri_so),
      .gt_pd(gt_pd), .eq_pd(eq_pd), .lt_pd(lt_pd),
      .gt_lvl(gt_lvl), .eq_lvl(eq_lvl), .lt_lvl(lt_lvl)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // expected {gt,eq,lt} levels
   function automatic logic [2:0] exp_lvl(input logic [7:0] r, input logic [7:0] b,
                                          input logic m, input logic sen, input logic pri);
      logic g, l, e;
      g = m ? ($signed(r) > $signed(b)) : (r > b);
      l = m ? ($signed(r) < $signed(b)) : (r < b);
      e = (r == b);
      if (sen) return 3'b111;
      if (!pri) return {1'b1, e, 1'b1};
      return {g, e, l};
   endfunction

   task automatic cyc(input logic [1:0] s, input logic m, input logic sen,
                      input logic pri, input logic [7:0] b, input string ctx);
      logic [2:0] el;
      string tag;
      sel = s; cmp_signed = m; stat_en_n = sen; pri_si = pri; bus_in = b;
      #1;
      el  = exp_lvl(mq, b, m, sen, pri);
      tag = sen ? "R8" : (!pri ? "R9" : (m ? "R7" : "R6"));
      chk({gt_lvl, eq_lvl, lt_lvl} == el, {tag, " status ", ctx}, {gt_lvl, eq_lvl, lt_lvl}, el);
      chk({gt_pd, eq_pd, lt_pd} == ~{gt_lvl, eq_lvl, lt_lvl}, "R11 pull-down vs level",
          {gt_pd, eq_pd, lt_pd}, ~{gt_lvl, eq_lvl, lt_lvl});
      chk(bus_oe == (s == 2'b01), {"R3 bus_oe ", ctx}, bus_oe, (s == 2'b01));
      if (s == 2'b01) chk(bus_out == mq, {"R3 read value ", ctx}, bus_out, mq);
      else            chk(bus_out == 8'h00, "R3 bus idle", bus_out, 0);
      if (s == 2'b10) chk(pri_so == mq[7], "R5 serial out", pri_so, mq[7]);
      else            chk(pri_so == (pri & (mq == b)), "R10 priority out", pri_so, (pri & (mq == b)));
      @(posedge clk);
      case (s)
         2'b10:   mq = {mq[6:0], pri};
         2'b11:   mq = b;
         default: mq = mq;
      endcase
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      rst = 1'b1; sel = 2'b11; cmp_signed = 0; stat_en_n = 0; pri_si = 1; bus_in = 8'h5A;
      repeat (3) @(negedge clk);
      rst = 1'b0; mq = 8'h00;
      // R1: reset clears register
      cyc(2'b01, 0, 0, 1, 8'h33, "R1 after reset");
      // R4: load
      cyc(2'b11, 0, 0, 1, 8'hA5, "R4 load");
      cyc(2'b01, 0, 0, 1, 8'h00, "R4 readback");
      // R2: hold with a changing bus
      cyc(2'b00, 0, 0, 1, 8'hFF, "R2 hold");
      cyc(2'b00, 0, 0, 1, 8'h12, "R2 hold");
      cyc(2'b01, 0, 0, 1, 8'hA5, "R2 readback");
      // R6 / R7: sign-sensitive corner
      cyc(2'b11, 0, 0, 1, 8'h80, "load 80");
      cyc(2'b00, 0, 0, 1, 8'h7F, "R6 80>7F unsigned");
      cyc(2'b00, 1, 0, 1, 8'h7F, "R7 80<7F signed");
      cyc(2'b00, 1, 0, 1, 8'hFF, "R7 80<FF signed");
      cyc(2'b00, 0, 0, 1, 8'h80, "R6 equal");
      // R8 / R9 / R10
      cyc(2'b00, 0, 1, 1, 8'h00, "R8 disabled");
      cyc(2'b00, 0, 0, 0, 8'h00, "R9 no priority unequal");
      cyc(2'b00, 0, 0, 0, 8'h80, "R9 no priority equal");
      cyc(2'b01, 0, 0, 1, 8'h80, "R10 read equal");
      // R5: shift a pattern in serially
      for (int i = 0; i < 8; i++) cyc(2'b10, 0, 0, (8'b1100_1010 >> (7 - i)) & 1'b1, 8'h00, "R5 shift");
      cyc(2'b01, 0, 0, 1, 8'h00, "R5 readback CA");
      chk(mq == 8'hCA, "R5 model pattern", mq, 8'hCA);
      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] s;
         logic [7:0] b;
         s = 2'($urandom);
         b = ($urandom_range(0, 3) == 0) ? mq : 8'($urandom);
         cyc(s, 1'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 3) != 0), b, "random");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule